// File: doc/BRIEF.md
# High-Frequency Clock Source Switcher With Deferred Commit

This block chooses which of two high-frequency oscillators, an RC oscillator or a crystal oscillator, drives the system clock. Software picks the wanted source with a select bit. The block enables that oscillator at once. It does not move the system clock yet. When the oscillator reports ready, the block raises a pending flag. Software may then set a separate permission bit. Only then does the block perform the handover.

The handover is glitch-free. Each source has its own gate. The gate is opened and closed on the falling edge of that source's own clock, after a two-flop synchroniser in that clock's domain. The gate of the new source can only open once the gate of the old source has closed. A status bit reports the source that actually drives the output. This bit can differ from the requested select. The pending flag stays up while the handover runs and drops when it is done. The oscillator that was left is switched off only after the handover completes.

All control logic and status flags live in the register-interface clock domain. The ready inputs and gate states enter that domain through two-stage synchronisers.

Top module: `hf_clk_switch`

## Requirements
- R1: After reset, `src_is_xo` is 0, `switch_pending` is 0, `rc_en` is 1 and `xo_en` is 0, and `clk_sys` runs from the RC oscillator.
- R2: The oscillator named by `sel_xo` (0 = RC, 1 = crystal) has its enable high one `clk_reg` cycle after the select takes that value, whether or not `switch_allow` is set.
- R3: When the requested source differs from the current one, `switch_pending` rises exactly three `clk_reg` edges after that source's ready input is first sampled high.
- R4: While `switch_allow` is 0, `src_is_xo` does not change and `clk_sys` keeps following the current source, even with a switch pending.
- R5: With a switch pending and `switch_allow` at 1, the handover completes. `src_is_xo` then takes the requested value (1 = crystal). `switch_pending` stays high until one `clk_reg` cycle after that update and then falls.
- R6: The oscillator that drives the output keeps its enable high the whole time. The abandoned one has its enable dropped one `clk_reg` cycle after `src_is_xo` changes, and not before.
- R7: `clk_sys` never shows a high or low phase shorter than the shorter of the two source half-periods, and the two source gates are never open together.
- R8: If the select returns to the current source while a switch is pending, `switch_pending` is low one cycle later, no handover happens even if permission is then granted, and the unneeded oscillator enable drops.
- R9: If `switch_allow` is already 1 when the select changes, the handover starts by itself once the new source is ready.
- R10: After a handover, `clk_sys` has the high-phase width of the newly selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-interface clock; all control and status run on it |
| rst | input | 1 | Synchronous active-high reset, `clk_reg` domain |
| sel_xo | input | 1 | Requested source: 0 RC oscillator, 1 crystal oscillator |
| switch_allow | input | 1 | Software permission to commit a pending handover |
| clk_rc | input | 1 | RC oscillator clock |
| clk_xo | input | 1 | Crystal oscillator clock |
| rc_ready | input | 1 | RC oscillator ready, asynchronous |
| xo_ready | input | 1 | Crystal oscillator ready, asynchronous |
| rc_en | output | 1 | RC oscillator enable |
| xo_en | output | 1 | Crystal oscillator enable |
| switch_pending | output | 1 | Requested source ready but not yet driving, or handover in progress |
| src_is_xo | output | 1 | Source that currently drives the output: 0 RC, 1 crystal |
| clk_sys | output | 1 | Glitch-free muxed system clock |

## Verification
The enables settle one `clk_reg` edge after the select changes. The pending flag rises on the third edge after a ready is first sampled high: two synchroniser stages and one status register. It falls one edge after the status bit flips. The bench drives inputs on falling edges of `clk_reg` and reads results on later falling edges, counting exactly those edges; where the exact edge matters it also checks the edge before, where the old value must still hold. The handover crosses two unrelated clock domains, so its length is not fixed. The bench waits for the status bit with a bound, then checks the cycle-exact consequences from that point. Phase widths on `clk_sys` are timed from edge to edge.

// File: rtl/hfsw_pkg.sv
package hfsw_pkg;

    typedef enum logic {
        SRC_RC = 1'b0,
        SRC_XO = 1'b1
    } src_e;

    typedef struct packed {
        logic rc;
        logic xo;
    } pair_t;

    localparam int SYNC_DEPTH = 2;

    function automatic src_e src_other(src_e s);
        return (s == SRC_RC) ? SRC_XO : SRC_RC;
    endfunction

    function automatic logic pair_pick(pair_t p, src_e s);
        return (s == SRC_XO) ? p.xo : p.rc;
    endfunction

    function automatic pair_t pair_onehot(src_e s);
        pair_t p;
        p.rc = (s == SRC_RC);
        p.xo = (s == SRC_XO);
        return p;
    endfunction

endpackage

// File: rtl/hfsw_sync.sv
module hfsw_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hfsw_leg.sv
module hfsw_leg #(
    parameter int STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_in,
    input  logic arm,
    output logic gate,
    output logic clk_out
);

    logic [STAGES-1:0] rst_chain;
    logic              rst_l;
    logic              arm_s;
    logic              gate_q;

    // reset brought into the source domain
    always_ff @(posedge clk_src) begin
        rst_chain <= {rst_chain[STAGES-2:0], rst_in};
    end
    assign rst_l = rst_chain[STAGES-1];

    hfsw_sync #(.STAGES(STAGES), .WIDTH(1)) u_arm_sync (
        .clk (clk_src),
        .rst (rst_l),
        .d   (arm),
        .q   (arm_s)
    );

    // gate changes only while this clock is low
    always_ff @(negedge clk_src) begin
        if (rst_l) gate_q <= 1'b0;
        else       gate_q <= arm_s;
    end

    assign gate    = gate_q;
    assign clk_out = clk_src & gate_q;

endmodule

// File: rtl/hfsw_ctrl.sv
module hfsw_ctrl
    import hfsw_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_xo,
    input  logic  switch_allow,
    input  pair_t ready_a,
    input  pair_t gate_a,
    output pair_t want,
    output pair_t osc_en,
    output logic  pending,
    output logic  src_is_xo
);

    pair_t rdy_s;
    pair_t gate_s;
    src_e  sel;
    src_e  tgt_q;
    src_e  cur_q;
    pair_t en_q;
    logic  pend_q;
    logic  busy;
    logic  rdy_req;
    logic  commit;
    logic  landed;

    hfsw_sync #(.STAGES(STAGES), .WIDTH(2)) u_rdy_sync (
        .clk (clk),
        .rst (rst),
        .d   (ready_a),
        .q   (rdy_s)
    );

    hfsw_sync #(.STAGES(STAGES), .WIDTH(2)) u_gate_sync (
        .clk (clk),
        .rst (rst),
        .d   (gate_a),
        .q   (gate_s)
    );

    assign sel     = src_e'(sel_xo);
    assign busy    = (tgt_q != cur_q);
    assign rdy_req = pair_pick(rdy_s, sel);
    assign commit  = !busy && (sel != tgt_q) && rdy_req && switch_allow;
    assign landed  = pair_pick(gate_s, tgt_q) && !pair_pick(gate_s, src_other(tgt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= SRC_RC;
            cur_q  <= SRC_RC;
            pend_q <= 1'b0;
            en_q   <= pair_onehot(SRC_RC);
        end else begin
            if (commit) tgt_q <= sel;
            if (busy && landed) cur_q <= tgt_q;
            pend_q <= busy || ((sel != tgt_q) && rdy_req);
            en_q   <= pair_onehot(sel) | pair_onehot(tgt_q) | pair_onehot(cur_q);
        end
    end

    assign want      = pair_onehot(tgt_q);
    assign osc_en    = en_q;
    assign pending   = pend_q;
    assign src_is_xo = (cur_q == SRC_XO);

    // R4: a new target is only taken with permission present
    a_r4_commit_needs_allow: assert property (@(posedge clk) disable iff (rst)
        (tgt_q != $past(tgt_q)) |-> $past(switch_allow));

    // R5: reported source only moves onto the committed target
    a_r5_status_to_target: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q)) |-> (cur_q == tgt_q));

    // R6: both oscillators stay enabled during a handover
    a_r6_both_on_in_flight: assert property (@(posedge clk) disable iff (rst)
        busy |-> (en_q.rc && en_q.xo));

endmodule

// File: rtl/hf_clk_switch.sv
module hf_clk_switch
    import hfsw_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic clk_reg,
    input  logic rst,
    input  logic sel_xo,
    input  logic switch_allow,
    input  logic clk_rc,
    input  logic clk_xo,
    input  logic rc_ready,
    input  logic xo_ready,
    output logic rc_en,
    output logic xo_en,
    output logic switch_pending,
    output logic src_is_xo,
    output logic clk_sys
);

    pair_t want;
    pair_t arm;
    pair_t gate;
    pair_t en;
    pair_t rdy;
    logic  clk_rc_g;
    logic  clk_xo_g;

    assign rdy.rc = rc_ready;
    assign rdy.xo = xo_ready;

    hfsw_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk          (clk_reg),
        .rst          (rst),
        .sel_xo       (sel_xo),
        .switch_allow (switch_allow),
        .ready_a      (rdy),
        .gate_a       (gate),
        .want         (want),
        .osc_en       (en),
        .pending      (switch_pending),
        .src_is_xo    (src_is_xo)
    );

    // each leg may open only once the other is closed
    assign arm.rc = want.rc & ~gate.xo;
    assign arm.xo = want.xo & ~gate.rc;

    hfsw_leg #(.STAGES(STAGES)) u_leg_rc (
        .clk_src (clk_rc),
        .rst_in  (rst),
        .arm     (arm.rc),
        .gate    (gate.rc),
        .clk_out (clk_rc_g)
    );

    hfsw_leg #(.STAGES(STAGES)) u_leg_xo (
        .clk_src (clk_xo),
        .rst_in  (rst),
        .arm     (arm.xo),
        .gate    (gate.xo),
        .clk_out (clk_xo_g)
    );

    assign clk_sys = clk_rc_g | clk_xo_g;
    assign rc_en   = en.rc;
    assign xo_en   = en.xo;

    // R7: gates are mutually exclusive
    a_r7_gates_exclusive: assert property (@(posedge clk_rc) disable iff (rst)
        !(gate.rc && gate.xo));

endmodule

// File: tb/hf_clk_switch_tb.sv
module hf_clk_switch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RC_HALF    = 3;
    localparam int XO_HALF    = 7;
    localparam int MIN_PHASE  = 3;
    localparam int RDY_DLY    = 8;
    localparam int WD_LIMIT   = 150000;

    logic clk_reg = 0, clk_rc = 0, clk_xo = 0;
    logic rst = 1, sel_xo = 0, switch_allow = 0;
    logic rc_ready = 0, xo_ready = 0;
    logic rc_en, xo_en, switch_pending, src_is_xo, clk_sys;

    int checks = 0, fails = 0, cycles = 0, runts = 0, hi_w = 0;
    int rc_cnt = 0, xo_cnt = 0;
    longint last_t = 0;
    bit have_last = 0, done = 0;
    logic prev_cur = 0;

    always #(CLK_PERIOD/2) clk_reg = ~clk_reg;
    always #(RC_HALF) clk_rc = ~clk_rc;
    always #(XO_HALF) clk_xo = ~clk_xo;

    hf_clk_switch u_dut (
        .clk_reg(clk_reg), .rst(rst), .sel_xo(sel_xo), .switch_allow(switch_allow),
        .clk_rc(clk_rc), .clk_xo(clk_xo), .rc_ready(rc_ready), .xo_ready(xo_ready),
        .rc_en(rc_en), .xo_en(xo_en), .switch_pending(switch_pending),
        .src_is_xo(src_is_xo), .clk_sys(clk_sys)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk_reg);
    endtask

    task automatic wait_src(logic want_src, int limit, output bit ok);
        ok = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk_reg);
            if (src_is_xo == want_src) begin ok = 1; break; end
        end
    endtask

    // oscillator model: ready after RDY_DLY enabled cycles
    always @(posedge clk_reg) begin
        #3;
        rc_cnt   = rc_en ? ((rc_cnt < RDY_DLY) ? rc_cnt + 1 : rc_cnt) : 0;
        xo_cnt   = xo_en ? ((xo_cnt < RDY_DLY) ? xo_cnt + 1 : xo_cnt) : 0;
        rc_ready = (rc_cnt == RDY_DLY);
        xo_ready = (xo_cnt == RDY_DLY);
    end

    // per-cycle reference: rules every cycle must satisfy
    always @(posedge clk_reg) begin
        #2;
        cycles++;
        if (!rst && !done) begin
            check("R2 requested oscillator enabled", sel_xo ? xo_en : rc_en, 1);
            check("R6 driving oscillator enabled", src_is_xo ? xo_en : rc_en, 1);
            if (src_is_xo != prev_cur)
                check("R4 status moved only with permission", switch_allow, 1);
        end
        prev_cur = src_is_xo;
        if (cycles > WD_LIMIT && !done) begin
            check("watchdog expired", 0, 1);
            finish_run();
        end
    end

    // output phase monitor
    always @(clk_sys) begin
        if (rst) have_last = 0;
        else begin
            if (have_last) begin
                if ($time - last_t < MIN_PHASE) runts++;
                if (clk_sys == 1'b0) hi_w = int'($time - last_t);
            end
            have_last = 1;
            last_t = $time;
        end
    end

    initial begin
        bit ok;
        tick(10);
        rst = 0;
        tick(20);
        // R1 reset state
        check("R1 src_is_xo", src_is_xo, 0);
        check("R1 switch_pending", switch_pending, 0);
        check("R1 rc_en", rc_en, 1);
        check("R1 xo_en", xo_en, 0);
        check("R1 clk_sys high width from RC", hi_w, RC_HALF);

        // request crystal without permission
        sel_xo = 1;
        tick(1);
        check("R2 xo_en one cycle after select", xo_en, 1);
        while (!xo_ready) tick(1);
        tick(2);
        check("R3 pending not yet after two edges", switch_pending, 0);
        tick(1);
        check("R3 pending on third edge", switch_pending, 1);
        tick(50);
        check("R4 no switch without permission", src_is_xo, 0);
        check("R4 clk_sys still RC width", hi_w, RC_HALF);

        // grant permission
        switch_allow = 1;
        wait_src(1'b1, 200, ok);
        check("R5 handover completed", int'(ok), 1);
        check("R5 pending still high at status change", switch_pending, 1);
        check("R6 old enable kept at status change", rc_en, 1);
        tick(1);
        check("R5 pending dropped after completion", switch_pending, 0);
        check("R6 old enable dropped after completion", rc_en, 0);
        switch_allow = 0;
        tick(10);
        check("R10 clk_sys crystal width", hi_w, XO_HALF);
        check("R7 no runt phases, switch to crystal", runts, 0);

        // request RC, then revert while pending
        sel_xo = 0;
        tick(30);
        check("R8 pending for RC request", switch_pending, 1);
        sel_xo = 1;
        tick(1);
        check("R8 pending cleared on revert", switch_pending, 0);
        check("R8 unneeded RC enable dropped", rc_en, 0);
        switch_allow = 1;
        tick(40);
        check("R8 no handover after revert", src_is_xo, 1);
        check("R8 pending stays low", switch_pending, 0);
        switch_allow = 0;
        tick(20);

        // permission set before select change
        switch_allow = 1;
        tick(1);
        sel_xo = 0;
        wait_src(1'b0, 200, ok);
        check("R9 automatic handover with prior permission", int'(ok), 1);
        tick(2);
        check("R9 pending cleared", switch_pending, 0);
        check("R6 crystal enable dropped", xo_en, 0);
        switch_allow = 0;
        tick(10);
        check("R10 clk_sys RC width", hi_w, RC_HALF);
        check("R7 no runt phases overall", runts, 0);
        finish_run();
    end

endmodule